// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Aggregator

This block turns already-filtered GPIO pin levels into interrupt and wake events for a bank of pins. Each pin owns a configuration word holding its trigger type, active polarity, interrupt enable, interrupt unmask, three sleep-state wake enables and a debounce setting. It also holds two sticky status bits, one for interrupt and one for wake, that software clears by writing ones. The block folds all pins into a group summary vector, one bit per four pins, which software reads as two 32-bit words. It drives a single registered interrupt line that software re-arms with an end-of-interrupt write to a master register.

When enabled in the master register, any change to a pin's debounce setting opens a blocking window for the whole bank. The window is counted in slow-clock ticks. While it lasts no status bit of any pin can be set, and every pin's interrupt-enable bit reads back as 0. Access goes through a simple single-cycle register port: writes take effect on the clock edge and reads are combinational.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset every configuration, status and master field is 0, the summary words read 0 and `irq_o` is low.
- R2: In edge mode (pin word bit 0 = 0), polarity code 0 (bits 2:1) sets the interrupt status on a rising pin level only, and code 1 sets it on a falling level only.
- R3: In edge mode, polarity code 2 sets the status on both rising and falling levels, and code 3 never sets it.
- R4: In level mode (bit 0 = 1), code 0 sets the status in every cycle the pin is high and code 1 in every cycle it is low, so a clear written while the level persists leaves the status set.
- R5: In level mode, polarity code 2 never sets the status.
- R6: The interrupt status (bit 16) is set only if interrupt enable (bit 3) is 1. The wake status (bit 17) is set by the same event if any of the three wake enables (bits 7:5) is 1, independently of bit 3.
- R7: `irq_o` rises one cycle after a pin has interrupt status set with unmask (bit 4) = 1, and stays low for statuses whose unmask bit is 0.
- R8: Writing a pin word with bit 16 or bit 17 set clears that status bit, and writing 0 there leaves it unchanged.
- R9: Summary bit g is set when any of pins 4g to 4g+3 has interrupt or wake status. Bits 0-31 read at address NPINS, bits 32-63 at address NPINS+1, and bits at or above NPINS/4 read 0.
- R10: Writing the master register (address NPINS+2) with bit 13 set drives `irq_o` low in the next cycle. It goes high again one cycle later if an unmasked interrupt status is still set.
- R11: With master bit 12 set, a pin write that changes that pin's debounce field (bits 11:8) loads the window counter from master bits 11:0. While the counter is nonzero no status bit is set on any pin, bit 3 of every pin word reads 0 and master bit 14 reads 1. Each slow tick decrements the counter. With master bit 12 clear no window opens.
- R12: A pin word read returns the current pin level in bit 18 and the stored configuration fields at their write positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NPINS | Filtered pin levels |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| reg_valid | input | 1 | Register access valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bound checker watches the interrupt line on every cycle. It confirms that the line drops after every end-of-interrupt write, follows pending unmasked status with one cycle of latency, and never rises without a pending source. It also confirms that no status bit rises while the blocking window is open and that each slow tick lowers the window counter by one. Which events each trigger and polarity combination detects, the write-one-to-clear behaviour against persistent levels, the summary grouping and the masked read of the enable bit can only be shown by the bench's directed scenarios and its random pin sequences checked against a reference model.

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int NPINS = 184,
  parameter int LEN_W = 12,
  localparam int AW = $clog2(NPINS + 3),
  localparam int NGRP = NPINS / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic             slow_tick,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_o
);
  localparam int SUM0 = NPINS;
  localparam int SUM1 = NPINS + 1;
  localparam int MST  = NPINS + 2;

  logic [NPINS-1:0] trig_q, en_q, unm_q, ists_q, wsts_q, lvl_q;
  logic [NPINS-1:0] evt, wr_pin, dbw_v, wen_any;
  logic [1:0] act_q [NPINS];
  logic [2:0] wen_q [NPINS];
  logic [3:0] db_q  [NPINS];
  logic prime_q, mse_q, irq_q;
  logic [LEN_W-1:0] len_q, blk_cnt;
  logic [63:0] sum;

  wire wr      = reg_valid & reg_write;
  wire mst_wr  = wr && (reg_addr == AW'(MST));
  wire eoi     = mst_wr & reg_wdata[13];
  wire blk     = |blk_cnt;
  wire dbw_any = |dbw_v;
  wire pend    = |(ists_q & unm_q);

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      wr_pin[i]  = wr && (reg_addr == AW'(i));
      dbw_v[i]   = wr_pin[i] && (reg_wdata[11:8] != db_q[i]);
      wen_any[i] = |wen_q[i];
      if (trig_q[i])
        evt[i] = (act_q[i] == 2'd0) ? pin_lvl[i] :
                 (act_q[i] == 2'd1) ? ~pin_lvl[i] : 1'b0;
      else
        evt[i] = (act_q[i] == 2'd0) ? (pin_lvl[i] & ~lvl_q[i]) :
                 (act_q[i] == 2'd1) ? (~pin_lvl[i] & lvl_q[i]) :
                 (act_q[i] == 2'd2) ? (pin_lvl[i] ^ lvl_q[i]) : 1'b0;
      evt[i] = evt[i] & prime_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prime_q <= 1'b0;
      lvl_q <= '0; trig_q <= '0; en_q <= '0; unm_q <= '0;
      ists_q <= '0; wsts_q <= '0;
      for (int i = 0; i < NPINS; i++) begin
        act_q[i] <= '0; wen_q[i] <= '0; db_q[i] <= '0;
      end
    end else begin
      prime_q <= 1'b1;
      lvl_q <= pin_lvl;
      for (int i = 0; i < NPINS; i++) begin
        if (wr_pin[i]) begin
          trig_q[i] <= reg_wdata[0];
          act_q[i]  <= reg_wdata[2:1];
          en_q[i]   <= reg_wdata[3];
          unm_q[i]  <= reg_wdata[4];
          wen_q[i]  <= reg_wdata[7:5];
          db_q[i]   <= reg_wdata[11:8];
        end
        ists_q[i] <= (ists_q[i] & ~(wr_pin[i] & reg_wdata[16])) |
                     (evt[i] & en_q[i] & ~blk);
        wsts_q[i] <= (wsts_q[i] & ~(wr_pin[i] & reg_wdata[17])) |
                     (evt[i] & wen_any[i] & ~blk);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0; mse_q <= 1'b0; blk_cnt <= '0; irq_q <= 1'b0;
    end else begin
      if (mst_wr) begin
        len_q <= reg_wdata[LEN_W-1:0];
        mse_q <= reg_wdata[12];
      end
      if (dbw_any && mse_q) blk_cnt <= len_q;
      else if (slow_tick && blk) blk_cnt <= blk_cnt - 1'b1;
      irq_q <= eoi ? 1'b0 : pend;
    end
  end

  always_comb begin
    sum = '0;
    for (int g = 0; g < NGRP; g++) sum[g] = |(ists_q[4*g +: 4] | wsts_q[4*g +: 4]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < AW'(NPINS)) begin
      reg_rdata[0]     = trig_q[reg_addr];
      reg_rdata[2:1]   = act_q[reg_addr];
      reg_rdata[3]     = en_q[reg_addr] & ~blk;
      reg_rdata[4]     = unm_q[reg_addr];
      reg_rdata[7:5]   = wen_q[reg_addr];
      reg_rdata[11:8]  = db_q[reg_addr];
      reg_rdata[16]    = ists_q[reg_addr];
      reg_rdata[17]    = wsts_q[reg_addr];
      reg_rdata[18]    = pin_lvl[reg_addr];
    end else if (reg_addr == AW'(SUM0)) begin
      reg_rdata = sum[31:0];
    end else if (reg_addr == AW'(SUM1)) begin
      reg_rdata = sum[63:32];
    end else if (reg_addr == AW'(MST)) begin
      reg_rdata[LEN_W-1:0] = len_q;
      reg_rdata[12] = mse_q;
      reg_rdata[14] = blk;
    end
  end

  assign irq_o = irq_q;
endmodule

module gpio_irq_agg_chk #(
  parameter int NPINS = 184,
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eoi,
  input logic             pend,
  input logic             irq_o,
  input logic             blk,
  input logic             slow_tick,
  input logic             dbw_any,
  input logic             mse_q,
  input logic [LEN_W-1:0] blk_cnt,
  input logic [NPINS-1:0] ists_q,
  input logic [NPINS-1:0] wsts_q
);
  assert_eoi_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq_o);

  assert_pend_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !eoi) |=> irq_o);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pend));

  assert_block_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> (((ists_q & ~$past(ists_q)) == '0) && ((wsts_q & ~$past(wsts_q)) == '0)));

  assert_block_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && slow_tick && !(dbw_any && mse_q)) |=> (blk_cnt == $past(blk_cnt) - 1'b1));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NPINS(NPINS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eoi(eoi), .pend(pend), .irq_o(irq_o),
  .blk(blk), .slow_tick(slow_tick), .dbw_any(dbw_any), .mse_q(mse_q),
  .blk_cnt(blk_cnt), .ists_q(ists_q), .wsts_q(wsts_q)
);

// File: tb/gpio_irq_agg_bench.sv
module gpio_irq_agg_bench;
  localparam int NPINS = 184;
  localparam int AW = $clog2(NPINS + 3);
  localparam int SUM0 = NPINS, SUM1 = NPINS + 1, MST = NPINS + 2;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic [NPINS-1:0] pins = '0;
  logic irq_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [7:0] m_cfg [8];
  logic [7:0] m_is = '0, m_ws = '0, m_prev = '0;
  logic m_irq = 1'b0;
  bit mdl_on = 0;

  always #2 clk = ~clk;

  gpio_irq_agg u_gpio_irq_agg (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .slow_tick(slow_tick),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic evt_f(logic [7:0] c, logic cur, logic prv);
    if (c[0]) return (c[2:1] == 2'd0) ? cur : (c[2:1] == 2'd1) ? ~cur : 1'b0;
    case (c[2:1])
      2'd0: return cur & ~prv;
      2'd1: return ~cur & prv;
      2'd2: return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, got, exp);
    end
  endtask

  task automatic cyc();
    if (mdl_on) begin
      logic [7:0] unm;
      for (int k = 0; k < 8; k++) unm[k] = m_cfg[k][4];
      m_irq = |(m_is & unm);
      for (int k = 0; k < 8; k++) begin
        logic e, hit;
        e = evt_f(m_cfg[k], pins[k], m_prev[k]);
        hit = reg_valid && reg_write && (reg_addr == AW'(k));
        m_is[k] = (m_is[k] & ~(hit & reg_wdata[16])) | (e & m_cfg[k][3]);
        m_ws[k] = (m_ws[k] & ~(hit & reg_wdata[17])) | (e & |m_cfg[k][7:5]);
        if (hit) m_cfg[k] = reg_wdata[7:0];
      end
      m_prev = pins[7:0];
    end
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    cyc();
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = AW'(a);
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic stick();
    slow_tick = 1'b1; cyc(); slow_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 8; k++) m_cfg[k] = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    rd(0, rv);    chk("R1 pin word", rv, 0);
    rd(SUM0, rv); chk("R1 summary lo", rv, 0);
    rd(SUM1, rv); chk("R1 summary hi", rv, 0);
    rd(MST, rv);  chk("R1 master", rv, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // random rounds on pins 0..7 against the model (R2-R8)
    mdl_on = 1;
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 8; k++) wr(k, $urandom & 32'hFF);
      for (int s = 0; s < 200; s++) begin
        pins[7:0] = 8'($urandom);
        cyc();
      end
      chk("R7 random irq", {31'd0, irq_o}, {31'd0, m_irq});
      for (int k = 0; k < 8; k++) begin
        rd(k, rv);
        chk("R2-R6 random status", {30'd0, rv[17:16]}, {30'd0, m_ws[k], m_is[k]});
      end
      pins[7:0] = '0;
      for (int k = 0; k < 8; k++) wr(k, 32'h30000);
      for (int k = 0; k < 8; k++) wr(k, 32'h30000);
    end
    mdl_on = 0;
    cyc(); cyc();
    chk("R8 random cleared irq", {31'd0, irq_o}, 0);

    // R2 edge high / low
    wr(8, 32'h18); pins[8] = 1; cyc();
    rd(8, rv); chk("R2 rise sets", {31'd0, rv[16]}, 1);
    cyc(); chk("R7 irq after status", {31'd0, irq_o}, 1);
    wr(8, 32'h10018); pins[8] = 0; cyc();
    rd(8, rv); chk("R2 fall ignored in high", {31'd0, rv[16]}, 0);
    wr(8, 32'h1A); pins[8] = 1; cyc();
    rd(8, rv); chk("R2 rise ignored in low", {31'd0, rv[16]}, 0);
    pins[8] = 0; cyc();
    rd(8, rv); chk("R2 fall sets in low", {31'd0, rv[16]}, 1);
    // R3 both edges
    wr(8, 32'h1001C); pins[8] = 1; cyc();
    rd(8, rv); chk("R3 both rise", {31'd0, rv[16]}, 1);
    wr(8, 32'h1001C); pins[8] = 0; cyc();
    rd(8, rv); chk("R3 both fall", {31'd0, rv[16]}, 1);
    wr(8, 32'h1001E); pins[8] = 1; cyc(); pins[8] = 0; cyc();
    rd(8, rv); chk("R3 code 3 silent", {31'd0, rv[16]}, 0);
    // R4 level high persists through clear
    wr(8, 32'h19); pins[8] = 1; cyc();
    wr(8, 32'h10019);
    rd(8, rv); chk("R4 level re-sets", {31'd0, rv[16]}, 1);
    pins[8] = 0; cyc(); wr(8, 32'h10019);
    rd(8, rv); chk("R4 clear after level gone", {31'd0, rv[16]}, 0);
    // R5 level with both code
    wr(8, 32'h1D); pins[8] = 1; cyc(); pins[8] = 0; cyc(); pins[8] = 1; cyc();
    rd(8, rv); chk("R5 level both silent", {31'd0, rv[16]}, 0);
    pins[8] = 0; wr(8, 32'h30000);

    // R6 wake without interrupt enable
    wr(9, 32'h30); pins[9] = 1; cyc();
    rd(9, rv); chk("R6 wake only", {30'd0, rv[17:16]}, 32'd2);
    cyc(); chk("R6 no irq from wake", {31'd0, irq_o}, 0);
    wr(9, 32'h30080); pins[9] = 0; cyc(); pins[9] = 1; cyc();
    rd(9, rv); chk("R6 third wake enable", {30'd0, rv[17:16]}, 32'd2);
    wr(9, 32'h30000); pins[9] = 0;

    // R7 masked, R8 write zero keeps status
    wr(10, 32'h08); pins[10] = 1; cyc(); cyc(); cyc();
    chk("R7 masked no irq", {31'd0, irq_o}, 0);
    wr(10, 32'h18);
    rd(10, rv); chk("R8 zero write keeps", {31'd0, rv[16]}, 1);
    cyc(); chk("R7 unmask raises irq", {31'd0, irq_o}, 1);
    // R10 end of interrupt
    wr(MST, 32'h2000);
    chk("R10 eoi drops", {31'd0, irq_o}, 0);
    cyc(); chk("R10 re-asserts", {31'd0, irq_o}, 1);
    wr(10, 32'h10000); cyc();
    chk("R8 clear drops irq", {31'd0, irq_o}, 0);
    pins[10] = 0;

    // R9 summary grouping
    wr(181, 32'h08); pins[181] = 1; cyc();
    rd(SUM1, rv); chk("R9 group 45", rv, 32'h2000);
    rd(SUM0, rv); chk("R9 low word empty", rv, 0);
    wr(11, 32'h08); pins[11] = 1; cyc();
    rd(SUM0, rv); chk("R9 group 2", rv, 32'h4);
    wr(181, 32'h10000); wr(11, 32'h10000); pins[181] = 0; pins[11] = 0;

    // R12 readback
    pins[20] = 1; wr(20, 32'h3FF);
    rd(20, rv); chk("R12 cfg and level", rv & 32'h40FFF, 32'h403FF);
    wr(20, 32'h0); pins[20] = 0;

    // R11 blocking window
    wr(8, 32'h18); wr(12, 32'h08);
    wr(MST, 32'h1003);
    wr(12, 32'h508);
    rd(12, rv); chk("R11 enable reads 0", {31'd0, rv[3]}, 0);
    rd(MST, rv); chk("R11 window flag", {31'd0, rv[14]}, 1);
    pins[8] = 1; cyc();
    rd(8, rv); chk("R11 blocked status", {31'd0, rv[16]}, 0);
    stick(); stick();
    rd(MST, rv); chk("R11 still open", {31'd0, rv[14]}, 1);
    stick();
    rd(12, rv); chk("R11 enable back", {31'd0, rv[3]}, 1);
    pins[8] = 0; cyc(); pins[8] = 1; cyc();
    rd(8, rv); chk("R11 status after window", {31'd0, rv[16]}, 1);
    wr(MST, 32'h3); wr(12, 32'h608);
    rd(12, rv); chk("R11 no window when disabled", {31'd0, rv[3]}, 1);
    rd(MST, rv); chk("R11 flag clear", {31'd0, rv[14]}, 0);

    done = 1;
    finish_run();
  end
endmodule